// File: doc/BRIEF.md
# Cascaded Timebase LED Rotator

This block moves a single lit position across an 8-bit LED vector, one step per second, from a 100 MHz system clock. A chain of three counters divides the clock: the first stage marks microseconds, the second milliseconds and the third seconds. A one-cycle second tick fires only when all three stages sit at their terminal counts together. That tick advances a left rotation with wraparound, so the lit bit climbs from position 0 to position 7 and then returns to position 0.

The block makes its own reset from a raw active-high reset request and a clock-lock flag. Reset holds while the request is high or the lock flag is low, and the registers sample it on the rising clock edge as a synchronous reset. During reset every LED bit is 1, meaning lit. On the first clock after reset clears, the vector loads a single 1 in bit 0 and the divider starts counting from zero. The first rotation therefore comes exactly one tick period later. The stage terminal counts are parameters, so a short configuration can be used to check the wraparound in a short run.

Top module: `led_rotator`

## Requirements
- R1: The microsecond stage advances on every running cycle and returns to 0 after its terminal count `US_TERM` (default 99, 100 cycles per microsecond).
- R2: The millisecond and second stages advance only on cycles when the stage below them wraps, and each returns to 0 after its terminal count (`MS_TERM` and `S_TERM`, default 999 each). In all other cycles they hold their value.
- R3: `sec_tick` is 1 only in a cycle where all three stages are at their terminal counts together, and it is never high for two cycles in a row.
- R4: Internal reset is `rst_req | ~pll_lock`, sampled at the rising edge. After any edge that sees it, `led` is 8'hFF and `sec_tick` is 0.
- R5: On the first edge without reset, `led` loads 8'b0000_0001 and every stage counter stays at 0.
- R6: Each `sec_tick` rotates `led` left by one bit at the next edge, with bit 7 moving into bit 0, so 8'b1000_0000 is followed by 8'b0000_0001. Outside reset, exactly one bit of `led` is 1.
- R7: Between ticks, `led` holds its value.
- R8: After the load of R5, `sec_tick` fires for the first time after exactly (US_TERM+1)(MS_TERM+1)(S_TERM+1) cycles, and again every such period after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_req | input | 1 | Raw reset request, active high |
| pll_lock | input | 1 | Clock-lock status; reset holds while it is 0 |
| led | output | LED_W (8) | LED pattern, 1 = lit |
| sec_tick | output | 1 | One-cycle pulse once per divider period |

## Verification
Any wrong divider stage shows up only as a misplaced tick: a tick that is early, late or missing. That puts the next `led` step on the wrong cycle within one period. So the bench compares `led` and `sec_tick` on every cycle over more than eight full periods of a small configuration. This places any counter error within a single cycle of the period where it first goes wrong. A broken rotation or a broken wrap from bit 7 to bit 0 shows in the `led` value one edge after the tick. A missing reset term or a missing first-cycle load shows in the first sample after reset is applied or released.

// File: rtl/ledrot_pkg.sv
package ledrot_pkg;

  localparam int NUM_STAGES = 3;

  // Number of clock cycles between two second ticks for the given terminals.
  function automatic int tick_period(input int us_term, input int ms_term, input int s_term);
    return (us_term + 1) * (ms_term + 1) * (s_term + 1);
  endfunction

  // Bits needed to hold values 0..max_val.
  function automatic int bits_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ledrot_ctrl.sv
module ledrot_ctrl (
  input  logic clk,
  input  logic rst_req,
  input  logic pll_lock,
  output logic sys_rst,
  output logic run
);

  // Reset request merged with clock lock; consumers sample it at the edge.
  assign sys_rst = rst_req | ~pll_lock;

  // run stays low for the first cycle after reset so that cycle can load the pattern.
  always_ff @(posedge clk) begin
    if (sys_rst) run <= 1'b0;
    else         run <= 1'b1;
  end

endmodule

// File: rtl/ledrot_stage.sv
module ledrot_stage #(
  parameter int TERM = 99
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic adv,
  output logic at_term,
  output logic wrap
);

  localparam int W = ledrot_pkg::bits_for(TERM);
  localparam logic [W-1:0] TERM_V = W'(TERM);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] next_val(input logic [W-1:0] v);
    return (v == TERM_V) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (sys_rst)  cnt <= '0;
    else if (adv) cnt <= next_val(cnt);
  end

  assign at_term = (cnt == TERM_V);
  assign wrap    = adv & at_term;

  // R1 (and R2 for the higher stages): wrap back to zero after the terminal count.
  assert_wrap_R1: assert property (@(posedge clk) disable iff (sys_rst)
    (adv && at_term) |=> (cnt == '0));

  // R1: a step below the terminal count adds one.
  assert_step_R1: assert property (@(posedge clk) disable iff (sys_rst)
    (adv && !at_term) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R2: no advance, no change.
  assert_hold_R2: assert property (@(posedge clk) disable iff (sys_rst)
    !adv |=> $stable(cnt));

endmodule

// File: rtl/ledrot_timebase.sv
module ledrot_timebase #(
  parameter int US_TERM = 99,
  parameter int MS_TERM = 999,
  parameter int S_TERM  = 999
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic run,
  output logic tick
);

  import ledrot_pkg::*;

  localparam int STAGE_TERMS [NUM_STAGES] = '{US_TERM, MS_TERM, S_TERM};
  localparam int PERIOD = tick_period(US_TERM, MS_TERM, S_TERM);
  localparam int PW     = bits_for(PERIOD);

  logic [NUM_STAGES-1:0] adv;
  logic [NUM_STAGES-1:0] at_term;
  logic [NUM_STAGES-1:0] wrap;

  assign adv[0] = run;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    if (i > 0) begin : g_chain
      assign adv[i] = wrap[i-1];
    end
    ledrot_stage #(.TERM(STAGE_TERMS[i])) i_stage (
      .clk     (clk),
      .sys_rst (sys_rst),
      .adv     (adv[i]),
      .at_term (at_term[i]),
      .wrap    (wrap[i])
    );
  end

  assign tick = wrap[NUM_STAGES-1];

  // Period counter used only by the checks below.
  logic [PW-1:0] since_tick;
  always_ff @(posedge clk) begin
    if (sys_rst)   since_tick <= '0;
    else if (run)  since_tick <= tick ? '0 : since_tick + 1'b1;
  end

  // R3: tick only when every stage is at its terminal count.
  assert_tick_all_term_R3: assert property (@(posedge clk) disable iff (sys_rst)
    tick |-> (&at_term));

  // R3: tick is one cycle wide.
  assert_tick_single_R3: assert property (@(posedge clk) disable iff (sys_rst)
    tick |=> !tick);

  // R8: tick exactly at the end of each period, and never elsewhere.
  assert_period_R8: assert property (@(posedge clk) disable iff (sys_rst)
    tick |-> (since_tick == PW'(PERIOD - 1)));
  assert_period_due_R8: assert property (@(posedge clk) disable iff (sys_rst)
    (run && since_tick == PW'(PERIOD - 1)) |-> tick);

endmodule

// File: rtl/ledrot_shifter.sv
module ledrot_shifter #(
  parameter int LED_W = 8
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             run,
  input  logic             tick,
  output logic [LED_W-1:0] led
);

  localparam logic [LED_W-1:0] FIRST = LED_W'(1);

  function automatic logic [LED_W-1:0] rotl(input logic [LED_W-1:0] v);
    return {v[LED_W-2:0], v[LED_W-1]};
  endfunction

  always_ff @(posedge clk) begin
    if (sys_rst)    led <= '1;
    else if (!run)  led <= FIRST;
    else if (tick)  led <= rotl(led);
  end

  // R4: reset lights everything.
  assert_all_on_R4: assert property (@(posedge clk)
    sys_rst |=> (led == '1));

  // R5: first cycle out of reset loads the lowest bit.
  assert_first_load_R5: assert property (@(posedge clk) disable iff (sys_rst)
    !run |=> (led == FIRST));

  // R6: tick rotates left with wrap from the top bit.
  assert_rotate_R6: assert property (@(posedge clk) disable iff (sys_rst)
    (run && tick) |=> (led == rotl($past(led))));

  // R6: a single lit bit while running.
  assert_one_lit_R6: assert property (@(posedge clk) disable iff (sys_rst)
    run |-> ($countones(led) == 1));

  // R7: pattern holds between ticks.
  assert_hold_R7: assert property (@(posedge clk) disable iff (sys_rst)
    (run && !tick) |=> $stable(led));

endmodule

// File: rtl/led_rotator.sv
module led_rotator #(
  parameter int US_TERM = 99,
  parameter int MS_TERM = 999,
  parameter int S_TERM  = 999,
  parameter int LED_W   = 8
) (
  input  logic             clk,
  input  logic             rst_req,
  input  logic             pll_lock,
  output logic [LED_W-1:0] led,
  output logic             sec_tick
);

  logic sys_rst;
  logic run;
  logic tb_tick;

  ledrot_ctrl i_ctrl (
    .clk      (clk),
    .rst_req  (rst_req),
    .pll_lock (pll_lock),
    .sys_rst  (sys_rst),
    .run      (run)
  );

  ledrot_timebase #(
    .US_TERM (US_TERM),
    .MS_TERM (MS_TERM),
    .S_TERM  (S_TERM)
  ) i_timebase (
    .clk     (clk),
    .sys_rst (sys_rst),
    .run     (run),
    .tick    (tb_tick)
  );

  ledrot_shifter #(.LED_W(LED_W)) i_shifter (
    .clk     (clk),
    .sys_rst (sys_rst),
    .run     (run),
    .tick    (tb_tick),
    .led     (led)
  );

  assign sec_tick = tb_tick;

  // R4: no tick in the cycle after a reset edge.
  assert_no_tick_after_reset_R4: assert property (@(posedge clk)
    sys_rst |=> !sec_tick);

endmodule

// File: tb/test_led_rotator.sv
module test_led_rotator;

  localparam int CLK_PERIOD = 10;
  localparam int US_T = 2;
  localparam int MS_T = 3;
  localparam int S_T  = 1;
  localparam int N    = (US_T + 1) * (MS_T + 1) * (S_T + 1);

  logic       clk = 1'b0;
  logic       rst_req = 1'b1;
  logic       pll_lock = 1'b0;
  logic [7:0] led;
  logic       sec_tick;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_rotator #(
    .US_TERM (US_T),
    .MS_TERM (MS_T),
    .S_TERM  (S_T),
    .LED_W   (8)
  ) i_led_rotator (
    .clk      (clk),
    .rst_req  (rst_req),
    .pll_lock (pll_lock),
    .led      (led),
    .sec_tick (sec_tick)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // j = edges since the load edge; checks led and tick against arithmetic model.
  task automatic check_run(input int j);
    logic [7:0] exp_led;
    logic       exp_tick;
    exp_led  = 8'(1) << ((j / N) % 8);
    exp_tick = ((j % N) == N - 1);
    check("R6/R7/R8 led", led, exp_led);
    check("R1/R2/R3 sec_tick", {7'b0, sec_tick}, {7'b0, exp_tick});
  endtask

  task automatic release_and_sweep(input int cycles);
    rst_req  = 1'b0;
    pll_lock = 1'b1;
    @(negedge clk);
    check("R5 first load", led, 8'b0000_0001);
    check("R5 no tick", {7'b0, sec_tick}, 8'h00);
    for (int j = 1; j < cycles; j++) begin
      @(negedge clk);
      check_run(j);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset led", led, 8'hFF);
    check("R4 reset tick", {7'b0, sec_tick}, 8'h00);

    // lock high but reset request still high: still in reset
    pll_lock = 1'b1;
    @(negedge clk);
    check("R4 rst_req only", led, 8'hFF);

    // full sweep over more than eight periods covers wrap 1000_0000 -> 0000_0001
    release_and_sweep(8 * N + N + 5);

    // lock loss mid-run acts as reset
    pll_lock = 1'b0;
    @(negedge clk);
    check("R4 lock loss led", led, 8'hFF);
    check("R4 lock loss tick", {7'b0, sec_tick}, 8'h00);
    @(negedge clk);
    check("R4 lock loss hold", led, 8'hFF);

    // restart: divider begins from zero again
    release_and_sweep(3 * N + 2);

    // reset request pulse just before a tick is due
    for (int k = 0; k < N - 3; k++) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    check("R4 rst_req mid-run", led, 8'hFF);
    check("R4 rst_req tick", {7'b0, sec_tick}, 8'h00);
    release_and_sweep(2 * N + 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule